// File: doc/BRIEF.md
# MMU Fault Status Recorder

This block sits beside the memory management unit. It records the cause and the address of any access that lands on unassigned memory or on an address space that is not implemented. Each fault strobe loads a status word and an address register. The status word holds cause flags, a fixed fault-type code and a valid marker.

A fault that arrives while an earlier fault is still unread is flagged as an overflow. Software reads the status word through a read strobe, and the read clears it. A data-access trap request is raised for one cycle only when the MMU is enabled and no-fault mode is off. In every other case the fault is logged without a trap.

Top module: `mmu_fault_recorder`

## Requirements
- R1: After reset, faultStatus, faultAddr and trapReq are all zero.
- R2: A fault that arrives while faultStatus is zero loads faultStatus with the value 0x16 plus the cause flags. The 0x16 is fault type 5 in bits 4:2 together with the address-valid bit 1.
- R3: A fault that arrives while faultStatus is non-zero, with no status read in the same cycle, loads (1 | 0x16 | cause flags). The earlier content is discarded and bit 0 marks the overflow.
- R4: The cause flags are bit 16 for an alternate-space access, bit 5 for supervisor mode, bit 6 for an instruction fetch and bit 7 for a write. Each is set only if its input was high with the fault strobe.
- R5: faultAddr takes the full fault address in the cycle after each fault strobe and otherwise keeps its value.
- R6: With mmuEnable high and mmuNoFault low, trapReq is high in the cycle after a fault strobe and low in the cycle after a cycle without one.
- R7: When mmuEnable is low or mmuNoFault is high, no trap is requested, and the fault is still recorded as in R2 to R5.
- R8: A status read (statusRd high) without a fault clears faultStatus to zero in the next cycle and leaves faultAddr unchanged.
- R9: When a fault strobe and a status read coincide, the fault is recorded as in R2 and bit 0 stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| faultValid | input | 1 | One-cycle strobe: an access hit unassigned space |
| faultAddrIn | input | ADDR_W | Address of the faulting access |
| faultWrite | input | 1 | Faulting access was a write |
| faultExec | input | 1 | Faulting access was an instruction fetch |
| faultAsi | input | 1 | Faulting access used an alternate address space |
| faultSuper | input | 1 | Processor was in supervisor mode |
| mmuEnable | input | 1 | MMU control enable bit |
| mmuNoFault | input | 1 | MMU control no-fault bit |
| statusRd | input | 1 | Status register read strobe (clear on read) |
| faultStatus | output | STAT_W | Fault status register value |
| faultAddr | output | ADDR_W | Fault address register value |
| trapReq | output | 1 | One-cycle data-access trap request |

## Verification
The bench builds the block with ADDR_W = 12 and the default 32-bit status word. This keeps address patterns up to all-ones cheap to drive and keeps every status bit visible. It sweeps all 16 cause-flag combinations against all four enable/no-fault settings. Each combination runs with three prior states: status cleared by a read, status still holding an unread fault, and a read that coincides with the fault. This reaches every overflow, masking and trap-gating corner.

// File: rtl/mfr_pkg.sv
package mfr_pkg;

  // Status word field positions (software decodes these)
  localparam int BitFav     = 1;
  localparam int TypeLsb    = 2;
  localparam int BitSuper   = 5;
  localparam int BitExec    = 6;
  localparam int BitWrite   = 7;
  localparam int BitAsi     = 16;
  localparam logic [2:0] TypeUnassigned = 3'd5;
  localparam int MinStatW   = BitAsi + 1;

  typedef struct packed {
    logic isWrite;
    logic isExec;
    logic isAsi;
    logic isSuper;
  } faultFlags_t;

  typedef struct packed {
    logic loadFault;
    logic clearStat;
    logic markOvf;
  } ctlStrobe_t;

endpackage

// File: rtl/mfr_ctrl.sv
module mfr_ctrl
  import mfr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       faultValid,
  input  logic       statusRd,
  input  logic       statusBusy,
  input  logic       mmuEnable,
  input  logic       mmuNoFault,
  output ctlStrobe_t ctl,
  output logic       trapReq
);

  logic trapNext;

  always_comb begin
    ctl.loadFault = faultValid;
    ctl.clearStat = statusRd;
    // overflow only if an unread fault is still present
    ctl.markOvf   = faultValid & statusBusy & ~statusRd;
    trapNext      = faultValid & mmuEnable & ~mmuNoFault;
  end

  always_ff @(posedge clk) begin
    if (!rstN) trapReq <= 1'b0;
    else       trapReq <= trapNext;
  end

endmodule

// File: rtl/mfr_dpath.sv
module mfr_dpath
  import mfr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int STAT_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        ctl,
  input  faultFlags_t       flags,
  input  logic [ADDR_W-1:0] faultAddrIn,
  output logic [STAT_W-1:0] statusQ,
  output logic [ADDR_W-1:0] addrQ,
  output logic              statusBusy
);

  logic [STAT_W-1:0] causeWord;
  logic [STAT_W-1:0] baseWord;

  always_comb begin
    causeWord                     = '0;
    causeWord[BitFav]             = 1'b1;
    causeWord[TypeLsb +: 3]       = TypeUnassigned;
    causeWord[BitSuper]           = flags.isSuper;
    causeWord[BitExec]            = flags.isExec;
    causeWord[BitWrite]           = flags.isWrite;
    causeWord[BitAsi]             = flags.isAsi;
    baseWord                      = ctl.markOvf ? STAT_W'(1) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
      addrQ   <= '0;
    end else begin
      if (ctl.loadFault)      statusQ <= baseWord | causeWord;
      else if (ctl.clearStat) statusQ <= '0;
      if (ctl.loadFault)      addrQ   <= faultAddrIn;
    end
  end

  assign statusBusy = |statusQ;

endmodule

// File: rtl/mmu_fault_recorder.sv
module mmu_fault_recorder
  import mfr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int STAT_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              faultValid,
  input  logic [ADDR_W-1:0] faultAddrIn,
  input  logic              faultWrite,
  input  logic              faultExec,
  input  logic              faultAsi,
  input  logic              faultSuper,
  input  logic              mmuEnable,
  input  logic              mmuNoFault,
  input  logic              statusRd,
  output logic [STAT_W-1:0] faultStatus,
  output logic [ADDR_W-1:0] faultAddr,
  output logic              trapReq
);

  localparam int StatOk = (STAT_W >= MinStatW) ? 1 : 0;

  ctlStrobe_t  ctl;
  faultFlags_t flags;
  logic        statusBusy;

  initial begin
    if (StatOk == 0) $error("STAT_W too narrow for cause bits");
  end

  assign flags = '{isWrite: faultWrite, isExec: faultExec,
                   isAsi: faultAsi, isSuper: faultSuper};

  mfr_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .faultValid (faultValid),
    .statusRd   (statusRd),
    .statusBusy (statusBusy),
    .mmuEnable  (mmuEnable),
    .mmuNoFault (mmuNoFault),
    .ctl        (ctl),
    .trapReq    (trapReq)
  );

  mfr_dpath #(.ADDR_W(ADDR_W), .STAT_W(STAT_W)) uDpath (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .flags       (flags),
    .faultAddrIn (faultAddrIn),
    .statusQ     (faultStatus),
    .addrQ       (faultAddr),
    .statusBusy  (statusBusy)
  );

endmodule

// File: rtl/mfr_checker.sv
module mfr_checker #(
  parameter int ADDR_W = 32,
  parameter int STAT_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              faultValid,
  input logic [ADDR_W-1:0] faultAddrIn,
  input logic              faultAsi,
  input logic              mmuEnable,
  input logic              mmuNoFault,
  input logic              statusRd,
  input logic [STAT_W-1:0] faultStatus,
  input logic [ADDR_W-1:0] faultAddr,
  input logic              trapReq
);

  a_r2_type_field: assert property (@(posedge clk) disable iff (!rstN)
    faultValid |=> faultStatus[4:1] == 4'b1011);

  a_r3_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (faultValid && !statusRd && faultStatus != '0) |=> faultStatus[0]);

  a_r4_asi_flag: assert property (@(posedge clk) disable iff (!rstN)
    faultValid |=> faultStatus[16] == $past(faultAsi));

  a_r5_addr_load: assert property (@(posedge clk) disable iff (!rstN)
    faultValid |=> faultAddr == $past(faultAddrIn));

  a_r5_addr_hold: assert property (@(posedge clk) disable iff (!rstN)
    !faultValid |=> $stable(faultAddr));

  a_r6_trap_raise: assert property (@(posedge clk) disable iff (!rstN)
    (faultValid && mmuEnable && !mmuNoFault) |=> trapReq);

  a_r7_trap_gate: assert property (@(posedge clk) disable iff (!rstN)
    !(faultValid && mmuEnable && !mmuNoFault) |=> !trapReq);

  a_r8_clear_read: assert property (@(posedge clk) disable iff (!rstN)
    (statusRd && !faultValid) |=> faultStatus == '0);

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (faultValid && statusRd) |=> !faultStatus[0]);

endmodule

bind mmu_fault_recorder mfr_checker #(.ADDR_W(ADDR_W), .STAT_W(STAT_W)) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .faultValid  (faultValid),
  .faultAddrIn (faultAddrIn),
  .faultAsi    (faultAsi),
  .mmuEnable   (mmuEnable),
  .mmuNoFault  (mmuNoFault),
  .statusRd    (statusRd),
  .faultStatus (faultStatus),
  .faultAddr   (faultAddr),
  .trapReq     (trapReq)
);

// File: tb/sim_mmu_fault_recorder.sv
`timescale 1ns/1ps
module sim_mmu_fault_recorder;

  localparam int AW = 12;
  localparam int SW = 32;

  logic          clk = 1'b0;
  logic          rstN;
  logic          faultValid, faultWrite, faultExec, faultAsi, faultSuper;
  logic          mmuEnable, mmuNoFault, statusRd;
  logic [AW-1:0] faultAddrIn;
  logic [SW-1:0] faultStatus;
  logic [AW-1:0] faultAddr;
  logic          trapReq;

  int checks = 0;
  int failures = 0;

  logic [SW-1:0] expStat;
  logic [AW-1:0] expAddr;

  always #5 clk = ~clk;

  mmu_fault_recorder #(.ADDR_W(AW), .STAT_W(SW)) u0 (
    .clk(clk), .rstN(rstN), .faultValid(faultValid), .faultAddrIn(faultAddrIn),
    .faultWrite(faultWrite), .faultExec(faultExec), .faultAsi(faultAsi),
    .faultSuper(faultSuper), .mmuEnable(mmuEnable), .mmuNoFault(mmuNoFault),
    .statusRd(statusRd), .faultStatus(faultStatus), .faultAddr(faultAddr),
    .trapReq(trapReq)
  );

  task automatic chk(input string req, input logic [SW-1:0] act, input logic [SW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic idleInputs();
    faultValid = 0; faultWrite = 0; faultExec = 0; faultAsi = 0;
    faultSuper = 0; statusRd = 0; faultAddrIn = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rstN = 0; mmuEnable = 0; mmuNoFault = 0;
    idleInputs();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    // R1: reset state
    chk("R1 status", faultStatus, '0);
    chk("R1 addr", SW'(faultAddr), '0);
    chk("R1 trap", SW'(trapReq), '0);
    expStat = '0;
    expAddr = '0;

    for (int mode = 0; mode < 4; mode++) begin
      for (int fl = 0; fl < 16; fl++) begin
        for (int pre = 0; pre < 3; pre++) begin
          logic          trapOn;
          logic [AW-1:0] a;
          logic [SW-1:0] flagBits;
          trapOn = (mode == 1);   // mode bit0 = enable, bit1 = no-fault
          a = (mode == 0 && fl == 0 && pre == 0) ? '1 :
              AW'((mode * 48 + fl * 3 + pre) * 157 + 11);
          flagBits = '0;
          flagBits[7]  = fl[0];
          flagBits[6]  = fl[1];
          flagBits[16] = fl[2];
          flagBits[5]  = fl[3];

          if (pre == 0) begin
            // R8: status read clears, address untouched
            @(negedge clk);
            idleInputs(); statusRd = 1;
            @(negedge clk);
            statusRd = 0;
            expStat = '0;
            chk("R8 cleared", faultStatus, '0);
            chk("R8 addr kept", SW'(faultAddr), SW'(expAddr));
          end

          idleInputs();
          mmuEnable = mode[0]; mmuNoFault = mode[1];
          faultValid = 1; faultAddrIn = a;
          faultWrite = fl[0]; faultExec = fl[1]; faultAsi = fl[2]; faultSuper = fl[3];
          statusRd = (pre == 2);
          // expected per R2, R3, R4, R9
          if (expStat != '0 && pre != 2) expStat = 32'h17 | flagBits;
          else                           expStat = 32'h16 | flagBits;
          expAddr = a;
          @(negedge clk);
          idleInputs();
          if (pre == 1)      chk("R3 overflow", faultStatus, expStat);
          else if (pre == 2) chk("R9 coincident read", faultStatus, expStat);
          else               chk("R2 R4 fresh fault", faultStatus, expStat);
          chk("R5 addr load", SW'(faultAddr), SW'(expAddr));
          if (trapOn) chk("R6 trap raised", SW'(trapReq), 1);
          else        chk("R7 trap gated", SW'(trapReq), 0);
          @(negedge clk);
          chk("R6 trap pulse ends", SW'(trapReq), 0);
          chk("R5 addr hold", SW'(faultAddr), SW'(expAddr));
          chk("R7 status kept", faultStatus, expStat);
        end
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule